// File: doc/BRIEF.md
# Serially Programmed Direct Digital Synthesis Core

This block produces a digital sine sample on every master clock from a 28-bit phase accumulator. A 3-wire serial port loads its settings: a clock, a frame-sync signal that is active low, and a data line. Each 16-bit word updates one of five registers: a control register, two 28-bit tuning words and two phase offsets. On every clock the accumulator adds the tuning word chosen by a select pin. The offset chosen by a second select pin is added to the top accumulator bits. A quarter-wave sine table then turns that phase into an unsigned sample. Toggling the tuning select gives frequency-shift keying. Toggling the offset select gives phase-shift keying.

The serial pins are sampled by the master clock through a two-register synchronizer, so the serial clock can run far below the master clock. A tuning word can be loaded one 14-bit half at a time, or as a staged pair of words that takes effect only when the second word arrives. The sample output is a free-running stream with one new value per clock. It carries no valid or ready, because a phase accumulator cannot pause for a consumer, and so no back-pressure is accepted.

Top module: `dds_synth`

## Requirements
- R1: While reset is asserted and after its release, the sample output is mid-scale (512) and every register, staged half and the accumulator is zero.
- R2: A word is 16 bits, taken MSB first, one bit at each falling edge of the serial clock while frame-sync is low. The pins pass through two synchronizing registers, so a word acts at the third rising master clock edge after the pin transition that carries its 16th falling edge.
- R3: If frame-sync rises before 16 bits have arrived, the partial word is dropped and no register changes.
- R4: Word bits [15:14] choose the target: 00 control, 01 tuning word 0, 10 tuning word 1, 11 phase offset. For an offset, bit 13 picks offset 0 or 1 and bits [11:0] are the value. For a tuning word, bits [13:0] are the data.
- R5: Control bits: [13] is pair mode, [12] is the half select (1 for the upper 14 bits, 0 for the lower 14 bits), [8] is accumulator clear. All other bits are ignored.
- R6: Outside pair mode, a tuning-word write replaces only the selected half and leaves the other half unchanged.
- R7: In pair mode, the first word to a tuning register is staged as its lower half and the register does not change. A second word to the same register commits {second, first}. A word to the other tuning register restarts staging for that register. Leaving pair mode drops a staged half.
- R8: At every clock edge the accumulator adds the tuning word picked by fsel_i (0 or 1), modulo 2^28.
- R9: At every edge the phase register loads accumulator bits [27:16] plus the offset picked by psel_i, modulo 4096. At the next edge the sample register loads the sine of that phase.
- R10: For phase p, with s = sin(2*pi*(p+0.5)/4096) and m = round(511*|s|), the sample is 512+m when s > 0 and 511-m otherwise.
- R11: While the clear bit is set, the accumulator is loaded with zero on every edge and the sample is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| fsync_i | input | 1 | Frame sync, active low |
| sdata_i | input | 1 | Serial data, MSB first |
| fsel_i | input | 1 | Tuning word select |
| psel_i | input | 1 | Phase offset select |
| sample_o | output | OUT_W (10) | Unsigned sine sample |

## Verification
The bench builds the core with its default parameters: a 12-bit phase and a 10-bit sample. At that size every one of the 4096 phase points and the whole quarter table can be reached in a few thousand cycles. Large tuning words make the 28-bit accumulator wrap many times during the run, and the select pins can be switched while the accumulator is running. The behavioural model follows the serial synchronizer delay, so each staged, half-width or aborted write is checked at the exact edge where it should, or should not, change the output.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W - 2;
  localparam int CNT_W  = $clog2(WORD_W);

  localparam int CB_PAIR = 13;
  localparam int CB_HIGH = 12;
  localparam int CB_CLR  = 8;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'b00,
    TGT_TUNE0 = 2'b01,
    TGT_TUNE1 = 2'b10,
    TGT_PHASE = 2'b11
  } target_e;

  typedef struct packed {
    logic pair;
    logic high;
    logic clr;
  } ctrl_t;
endpackage

// File: rtl/dds_serial_rx.sv
module dds_serial_rx
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic [2:0]          sclk_q;
  logic [1:0]          fs_q;
  logic [1:0]          sd_q;
  logic [CNT_W-1:0]    cnt;
  logic [WORD_W-2:0]   shreg;
  logic                fall, fs, sd, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      fs_q   <= '1;
      sd_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      fs_q   <= {fs_q[0], fsync_i};
      sd_q   <= {sd_q[0], sdata_i};
    end
  end

  assign fall = !sclk_q[1] && sclk_q[2];
  assign fs   = fs_q[1];
  assign sd   = sd_q[1];
  assign last = fall && !fs && (cnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (fs) begin
      cnt <= '0;
    end else if (fall) begin
      shreg <= {shreg[WORD_W-3:0], sd};
      cnt   <= last ? '0 : cnt + 1'b1;
    end
  end

  assign word_valid_o = last;
  assign word_o       = {shreg, sd};

  AST_WORD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> (cnt == '0) && !word_valid_o) else $error("word restart"); // R2

  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && fall) |=> (cnt == '0)) else $error("abort keeps bits"); // R3
endmodule

// File: rtl/dds_regfile.sv
module dds_regfile
  import dds_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wvalid_i,
  input  logic [WORD_W-1:0]            word_i,
  output ctrl_t                        ctrl_o,
  output logic [1:0][2*HALF_W-1:0]     tune_o,
  output logic [1:0][PHASE_W-1:0]      poff_o
);
  localparam int ACC_W = 2 * HALF_W;

  ctrl_t                     ctrl_q;
  logic [1:0][ACC_W-1:0]     tune_q;
  logic [1:0][PHASE_W-1:0]   poff_q;
  logic [HALF_W-1:0]         low_q;
  logic                      pend_q, pend_idx_q;

  target_e                   tgt;
  logic                      tidx, is_tune, pair_hit;
  logic [HALF_W-1:0]         data;

  assign tgt      = target_e'(word_i[WORD_W-1 -: 2]);
  assign tidx     = (tgt == TGT_TUNE1);
  assign is_tune  = (tgt == TGT_TUNE0) || (tgt == TGT_TUNE1);
  assign data     = word_i[HALF_W-1:0];
  assign pair_hit = pend_q && (pend_idx_q == tidx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      tune_q     <= '0;
      poff_q     <= '0;
      low_q      <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= 1'b0;
    end else if (wvalid_i) begin
      unique case (tgt)
        TGT_CTRL: begin
          ctrl_q.pair <= word_i[CB_PAIR];
          ctrl_q.high <= word_i[CB_HIGH];
          ctrl_q.clr  <= word_i[CB_CLR];
          if (!word_i[CB_PAIR]) pend_q <= 1'b0;
        end
        TGT_TUNE0, TGT_TUNE1: begin
          if (ctrl_q.pair) begin
            if (pair_hit) begin
              tune_q[tidx] <= {data, low_q};
              pend_q       <= 1'b0;
            end else begin
              low_q      <= data;
              pend_q     <= 1'b1;
              pend_idx_q <= tidx;
            end
          end else if (ctrl_q.high) begin
            tune_q[tidx][ACC_W-1:HALF_W] <= data;
          end else begin
            tune_q[tidx][HALF_W-1:0] <= data;
          end
        end
        TGT_PHASE: poff_q[word_i[CB_PAIR]] <= word_i[PHASE_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign tune_o = tune_q;
  assign poff_o = poff_q;

  AST_PAIR_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid_i && is_tune && ctrl_q.pair && !pair_hit) |=> $stable(tune_q)) else $error("staged write changed tune"); // R7

  AST_PAIR_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid_i && is_tune && ctrl_q.pair && pair_hit)
      |=> tune_q[$past(tidx)][HALF_W-1:0] == $past(low_q)) else $error("pair commit low half"); // R7

  AST_HALF_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid_i && is_tune && !ctrl_q.pair && ctrl_q.high)
      |=> tune_q[$past(tidx)][HALF_W-1:0] == $past(tune_q[tidx][HALF_W-1:0])) else $error("upper write touched lower"); // R6
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [OUT_W-1:0]   sample_o
);
  localparam int  QW      = PHASE_W - 2;
  localparam int  ENTRIES = 2 ** QW;
  localparam int  MAG_W   = OUT_W - 1;
  localparam int  MID     = 2 ** (OUT_W - 1);
  localparam real AMAX    = real'(MID - 1);
  localparam real PI      = 3.14159265358979323846;

  logic [MAG_W-1:0] rom [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_rom
    localparam real ANG = (real'(k) + 0.5) * PI / (2.0 * real'(ENTRIES));
    assign rom[k] = MAG_W'($rtoi(AMAX * $sin(ANG) + 0.5));
  end

  logic [1:0]       quad;
  logic [QW-1:0]    idx;
  logic [MAG_W-1:0] mag;

  assign quad = phase_i[PHASE_W-1 -: 2];
  assign idx  = quad[0] ? ~phase_i[QW-1:0] : phase_i[QW-1:0];
  assign mag  = rom[idx];

  always_comb begin
    if (quad[1]) sample_o = OUT_W'(MID - 1) - OUT_W'(mag);
    else         sample_o = OUT_W'(MID) + OUT_W'(mag);
  end
endmodule

// File: rtl/dds_synth.sv
module dds_synth
  import dds_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             fsync_i,
  input  logic             sdata_i,
  input  logic             fsel_i,
  input  logic             psel_i,
  output logic [OUT_W-1:0] sample_o
);
  localparam int ACC_W = 2 * HALF_W;
  localparam logic [OUT_W-1:0] MID = OUT_W'(2 ** (OUT_W - 1));

  logic                      wvalid;
  logic [WORD_W-1:0]         word;
  ctrl_t                     ctrl;
  logic [1:0][ACC_W-1:0]     tune;
  logic [1:0][PHASE_W-1:0]   poff;

  logic [ACC_W-1:0]          acc_q, tword;
  logic [PHASE_W-1:0]        ph_q, pword;
  logic [OUT_W-1:0]          lut_out, samp_q;

  dds_serial_rx i_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .fsync_i(fsync_i),
    .sdata_i(sdata_i), .word_valid_o(wvalid), .word_o(word)
  );

  dds_regfile #(.PHASE_W(PHASE_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wvalid_i(wvalid), .word_i(word),
    .ctrl_o(ctrl), .tune_o(tune), .poff_o(poff)
  );

  dds_sine_lut #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) i_lut (
    .phase_i(ph_q), .sample_o(lut_out)
  );

  assign tword = tune[fsel_i];
  assign pword = poff[psel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      ph_q   <= '0;
      samp_q <= MID;
    end else begin
      acc_q  <= ctrl.clr ? '0 : acc_q + tword;
      ph_q   <= acc_q[ACC_W-1 -: PHASE_W] + pword;
      samp_q <= ctrl.clr ? MID : lut_out;
    end
  end

  assign sample_o = samp_q;

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.clr |=> acc_q == $past(acc_q) + $past(tword)) else $error("accumulator step"); // R8

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clr |=> acc_q == '0) else $error("clear ignored"); // R11

  AST_MID_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clr |=> sample_o == MID) else $error("sample not mid-scale"); // R11
endmodule

// File: tb/test_dds_synth.sv
module test_dds_synth;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, fsync = 1'b1, sdata = 1'b0, fsel = 1'b0, psel = 1'b0;
  logic [9:0] sample;

  always #10 clk = ~clk;

  dds_synth i_dds_synth (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_i(fsync),
    .sdata_i(sdata), .fsel_i(fsel), .psel_i(psel), .sample_o(sample)
  );

  int nchk = 0, nfail = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  longint macc;
  int mph, msamp, mcnt, msh, mlow, mpidx, n_acc, n_ph, n_samp;
  int mF[2];
  int mP[2];
  bit mpair, mhigh, mclr, mpend;
  bit h1s, h2s, h3s, h1f, h2f, h3f, h1d, h2d, h3d;

  function automatic int ref_sine(int p);
    real s, a;
    int m;
    s = $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 4096.0);
    a = (s < 0.0) ? -s : s;
    m = $rtoi(511.0 * a + 0.5);
    return (s > 0.0) ? 512 + m : 511 - m;
  endfunction

  task automatic apply_word(int w);
    int tgt, idx, d;
    tgt = (w >> 14) & 3;
    d = w & 16'h3FFF;
    case (tgt)
      0: begin
        mpair = w[13]; mhigh = w[12]; mclr = w[8];
        if (!w[13]) mpend = 0;
      end
      1, 2: begin
        idx = tgt - 1;
        if (mpair) begin
          if (mpend && mpidx == idx) begin mF[idx] = (d << 14) | mlow; mpend = 0; end
          else begin mlow = d; mpend = 1; mpidx = idx; end
        end else if (mhigh) mF[idx] = (mF[idx] & 16'h3FFF) | (d << 14);
        else mF[idx] = (mF[idx] & ~32'h3FFF) | d;
      end
      default: mP[w[13]] = w & 12'hFFF;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      macc = 0; mph = 0; msamp = 512; mcnt = 0; msh = 0; mlow = 0; mpidx = 0;
      mF[0] = 0; mF[1] = 0; mP[0] = 0; mP[1] = 0;
      mpair = 0; mhigh = 0; mclr = 0; mpend = 0;
      h1s = 1; h2s = 1; h3s = 1; h1f = 1; h2f = 1; h3f = 1; h1d = 0; h2d = 0; h3d = 0;
    end else begin
      n_samp = mclr ? 512 : ref_sine(mph);
      n_ph   = (int'(macc >> 16) + mP[psel]) % 4096;
      n_acc  = mclr ? 0 : int'((macc + longint'(mF[fsel])) % 64'd268435456);
      macc = n_acc; mph = n_ph; msamp = n_samp;
      if (h2f) mcnt = 0;
      else if (!h2s && h3s) begin
        msh = ((msh << 1) | h2d) & 16'hFFFF;
        mcnt++;
        if (mcnt == 16) begin apply_word(msh); mcnt = 0; end
      end
      h3s = h2s; h3f = h2f; h3d = h2d;
      h2s = h1s; h2f = h1f; h2d = h1d;
      h1s = sclk; h1f = fsync; h1d = sdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      nchk++;
      if (sample !== msamp[9:0]) begin
        nfail++;
        $display("FAIL %s: sample=%0d expected=%0d at %0t", cur_req, sample, msamp, $time);
      end
    end
  end

  task automatic send(input logic [15:0] w, input int nb);
    @(negedge clk) fsync = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdata = w[15-i]; sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    fsync = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1 reset";
    run(5);
    rst_n = 1'b1;
    run(20);

    cur_req = "R2 R4 R5 R6 R8 R10 half writes";
    send(16'h0000, 16);
    send(16'h4000 | 16'h1234, 16);
    send(16'h1000, 16);
    send(16'h4000 | 16'h0005, 16);
    run(3500);
    send(16'h1000 | 16'h0E00, 16);   // ignored control bits set
    send(16'h4000 | 16'h0301, 16);   // upper half only
    run(400);

    cur_req = "R4 R9 phase offsets PSK";
    send(16'hC123, 16);
    send(16'hE400, 16);
    for (int i = 0; i < 8; i++) begin psel = ~psel; run(50); end

    cur_req = "R6 R8 tune1 FSK";
    send(16'h0000, 16);
    send(16'h8000 | 16'h3FFF, 16);
    send(16'h1000, 16);
    send(16'h8000 | 16'h0100, 16);
    for (int i = 0; i < 8; i++) begin fsel = ~fsel; run(60); end

    cur_req = "R7 pair mode";
    send(16'h2000, 16);
    send(16'h8000 | 16'h0AAA, 16);
    run(30);
    send(16'h4000 | 16'h0111, 16);
    send(16'h4000 | 16'h0200, 16);
    run(50);
    send(16'h8000 | 16'h0333, 16);
    run(30);
    send(16'h8000 | 16'h0044, 16);
    for (int i = 0; i < 4; i++) begin fsel = ~fsel; run(40); end
    send(16'h4000 | 16'h0001, 16);
    send(16'h0000, 16);
    send(16'h2000, 16);
    send(16'h4000 | 16'h0002, 16);
    run(60);

    cur_req = "R3 aborted word";
    send(16'h0000, 16);
    send(16'h4000 | 16'h3FFF, 10);
    run(40);
    send(16'h8000 | 16'h2222, 15);
    run(40);
    send(16'hC000 | 16'h0FFF, 16);
    run(60);

    cur_req = "R11 clear bit";
    send(16'h0100, 16);
    run(80);
    send(16'h0000, 16);
    run(200);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule